// File: doc/BRIEF.md
# Triangular Spread-Spectrum Modulation Generator

This block produces a digital triangular offset that is added to the fractional multiplication factor of a clock synthesizer. Sweeping the factor spreads the synthesizer's emission energy over a band instead of a single line. The offset comes from an up/down accumulator. It moves by a programmed increment once every programmed number of reference cycles, and it reverses direction at the programmed crest and trough. The step period is programmable, so the triangle can be held near its target repetition rate (about 25 kHz) for any reference frequency between 4 and 40 MHz.

Two profiles are available. In center-spread the offset swings between plus and minus the programmed peak, which gives a symmetric spread of up to about ±2%. In down-spread it swings between zero and minus twice the peak, which gives up to about −4% and never goes above nominal. When the enable input drops, the offset walks back to zero at the normal step rate and then stays there. The factor therefore never jumps. Profile, peak and increment are taken only while the block is idle at zero offset. A change made at any other time waits until the block is idle again.

Top module: `ssm_gen`

## Requirements
- R1: While `rst_n` is low, on every clock edge `offset` becomes 0 and `mf_out` becomes 0.
- R2: While idle (not modulating, offset zero), `offset` stays 0 and `mf_out` equals `nom_mf` from the previous cycle.
- R3: The offset changes only on a step. Steps come every P reference cycles, where P is `cfg_period`, and the first step falls P cycles after modulation starts.
- R4: With `cfg_down`=0 the offset first rises by the increment per step, never exceeds +peak or goes below −peak, and reverses at each bound. A step that would overshoot a bound lands on the bound.
- R5: With `cfg_down`=1 the offset first falls, stays within [−2·peak, 0], and reverses at each bound with the same clamping.
- R6: After `mod_en` falls, each step moves the offset toward zero by the increment and stops at exactly zero. The block then returns to idle, and no single cycle changes the offset by more than the increment.
- R7: `cfg_down`, `cfg_peak` and `cfg_inc` are sampled only while idle. Changes made while modulating or returning have no effect until the next start from idle.
- R8: On every step, `mf_out` becomes `nom_mf` plus the sign-extended new offset, modulo 2^MF_W. Between steps it holds its value.
- R9: A `cfg_period` of 0 is treated as 1, and a `cfg_inc` of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mod_en | input | 1 | Modulation enable |
| cfg_down | input | 1 | 1 = down-spread, 0 = center-spread |
| cfg_peak | input | OFS_W-2 | Peak offset in fractional-factor LSBs |
| cfg_inc | input | OFS_W-2 | Offset increment per step |
| cfg_period | input | PER_W | Reference cycles per step |
| nom_mf | input | MF_W | Nominal multiplication factor |
| offset | output | OFS_W | Signed modulation offset |
| mf_out | output | MF_W | Nominal factor plus offset |

## Verification
The bench uses OFS_W=12, MF_W=20 and PER_W=8. With these values, peaks up to 60, increments up to 7 and step periods up to 6 complete many full triangles, clamped reversals and returns to zero within a few hundred cycles per run. The 20-bit nominal factor is drawn at random, which exercises wrap-around of the sum when the offset is negative. The small peak range also makes the degenerate cases likely: a zero peak, a zero increment and a zero period.

// File: rtl/ssm_pkg.sv
// Shared types of the spread-spectrum modulation generator.
package ssm_pkg;
    // Sequencer state: idle at zero, sweeping the triangle, returning to zero.
    typedef enum logic [1:0] {
        SSM_IDLE = 2'd0,
        SSM_RUN  = 2'd1,
        SSM_RET  = 2'd2
    } ssm_state_e;
endpackage

// File: rtl/ssm_tick.sv
// Step timer: raises tick once every `period` reference cycles while run is high.
// Assumes period may change at any time; a value of 0 behaves as 1.
module ssm_tick #(
    parameter int PER_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PER_W-1:0] period,
    output logic             tick
);
    logic [PER_W-1:0] cnt_q;
    logic [PER_W-1:0] last;

    // Last count value of a step interval.
    always_comb last = (period == '0) ? '0 : period - PER_W'(1);

    assign tick = run && (cnt_q >= last);

    // Count reference cycles within the current step; clear on a step or when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (!run || tick) cnt_q <= '0;
        else                 cnt_q <= cnt_q + PER_W'(1);
    end
endmodule

// File: rtl/ssm_ramp.sv
// Triangle accumulator and sequencer. Sweeps the signed offset between hi and lo
// bounds set by peak and profile, and walks back to zero once disabled.
// Assumes peak/inc/down are stable outside idle and inc is nonzero.
module ssm_ramp
    import ssm_pkg::*;
#(
    parameter int OFS_W = 16,
    localparam int PK_W = OFS_W - 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    tick,
    input  logic                    down,
    input  logic [PK_W-1:0]         peak,
    input  logic [PK_W-1:0]         inc,
    output logic signed [OFS_W-1:0] offset,
    output logic signed [OFS_W-1:0] offset_nxt,
    output logic                    idle
);
    localparam int SW = OFS_W + 1;

    ssm_state_e             st_q, st_d;
    logic                   dir_q, dir_d;      // 1 = rising
    logic signed [OFS_W-1:0] acc_q;
    logic signed [SW-1:0]   acc_w, inc_w, pk_w, hi, lo, up, dn, nxt;

    // Widen operands and derive the sweep bounds for the selected profile.
    always_comb begin
        acc_w = {acc_q[OFS_W-1], acc_q};
        inc_w = $signed({3'b000, inc});
        pk_w  = $signed({3'b000, peak});
        hi    = down ? '0 : pk_w;
        lo    = down ? -(pk_w <<< 1) : -pk_w;
        up    = acc_w + inc_w;
        dn    = acc_w - inc_w;
    end

    // Next offset, direction and state.
    always_comb begin
        nxt   = acc_w;
        dir_d = dir_q;
        st_d  = st_q;
        unique case (st_q)
            SSM_IDLE: begin
                nxt   = '0;
                dir_d = !down;
                if (en) st_d = SSM_RUN;
            end
            SSM_RUN, SSM_RET: begin
                if (st_q == SSM_RUN && en) begin
                    if (tick) begin
                        if (dir_q) begin
                            if (up >= hi) begin nxt = hi; dir_d = 1'b0; end
                            else          nxt = up;
                        end else begin
                            if (dn <= lo) begin nxt = lo; dir_d = 1'b1; end
                            else          nxt = dn;
                        end
                    end
                end else if (tick) begin
                    if (acc_w > 0)      nxt = (acc_w > inc_w)  ? dn : '0;
                    else if (acc_w < 0) nxt = (-acc_w > inc_w) ? up : '0;
                end
                if (st_q == SSM_RUN && !en)                 st_d = SSM_RET;
                else if (st_q == SSM_RET && acc_q == '0)    st_d = SSM_IDLE;
            end
            default: st_d = SSM_IDLE;
        endcase
    end

    // Register sequencer state, direction and offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SSM_IDLE;
            dir_q <= 1'b1;
            acc_q <= '0;
        end else begin
            st_q  <= st_d;
            dir_q <= dir_d;
            acc_q <= nxt[OFS_W-1:0];
        end
    end

    assign offset     = acc_q;
    assign offset_nxt = nxt[OFS_W-1:0];
    assign idle       = (st_q == SSM_IDLE);
endmodule

// File: rtl/ssm_gen.sv
// Spread-spectrum modulation generator top. Latches profile/peak/increment while
// idle, runs the step timer and triangle accumulator, and registers the final
// factor once per step. Assumes MF_W > OFS_W and synchronous active-low reset.
module ssm_gen #(
    parameter int OFS_W = 16,
    parameter int MF_W  = 24,
    parameter int PER_W = 12,
    localparam int PK_W = OFS_W - 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mod_en,
    input  logic                    cfg_down,
    input  logic [PK_W-1:0]         cfg_peak,
    input  logic [PK_W-1:0]         cfg_inc,
    input  logic [PER_W-1:0]        cfg_period,
    input  logic [MF_W-1:0]         nom_mf,
    output logic signed [OFS_W-1:0] offset,
    output logic [MF_W-1:0]         mf_out
);
    logic                    idle, tick;
    logic                    down_q, down_use;
    logic [PK_W-1:0]         peak_q, peak_use, inc_q, inc_use, inc_live;
    logic signed [OFS_W-1:0] off_nxt;
    logic [MF_W-1:0]         off_ext, mf_q;

    // Live configuration is used while idle, the latched copy otherwise.
    always_comb begin
        inc_live = (cfg_inc == '0) ? PK_W'(1) : cfg_inc;
        down_use = idle ? cfg_down : down_q;
        peak_use = idle ? cfg_peak : peak_q;
        inc_use  = idle ? inc_live : inc_q;
    end

    // Capture configuration only while idle at zero offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            down_q <= 1'b0;
            peak_q <= '0;
            inc_q  <= PK_W'(1);
        end else if (idle) begin
            down_q <= cfg_down;
            peak_q <= cfg_peak;
            inc_q  <= inc_live;
        end
    end

    ssm_tick #(.PER_W(PER_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (!idle),
        .period (cfg_period),
        .tick   (tick)
    );

    ssm_ramp #(.OFS_W(OFS_W)) u_ramp (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (mod_en),
        .tick       (tick),
        .down       (down_use),
        .peak       (peak_use),
        .inc        (inc_use),
        .offset     (offset),
        .offset_nxt (off_nxt),
        .idle       (idle)
    );

    assign off_ext = {{(MF_W-OFS_W){off_nxt[OFS_W-1]}}, off_nxt};

    // Register the output factor on each step, and track nominal while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)            mf_q <= '0;
        else if (idle || tick) mf_q <= nom_mf + off_ext;
    end

    assign mf_out = mf_q;
endmodule

// File: rtl/ssm_gen_chk.sv
// Property checker for ssm_gen, bound to every instance of the top.
module ssm_gen_chk #(
    parameter int OFS_W = 16,
    parameter int MF_W  = 24,
    localparam int PK_W = OFS_W - 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    idle,
    input logic                    tick,
    input logic                    down_q,
    input logic [PK_W-1:0]         peak_q,
    input logic [PK_W-1:0]         inc_q,
    input logic signed [OFS_W-1:0] offset,
    input logic [MF_W-1:0]         nom_mf,
    input logic [MF_W-1:0]         mf_out
);
    logic signed [OFS_W+1:0] pk_s, off_s, diff, prev_off, prev_inc;
    logic                    prev_v;
    logic [MF_W-1:0]         off_ext;

    always_comb begin
        pk_s    = $signed({4'b0000, peak_q});
        off_s   = {{2{offset[OFS_W-1]}}, offset};
        diff    = off_s - prev_off;
        off_ext = {{(MF_W-OFS_W){offset[OFS_W-1]}}, offset};
    end

    // Remember last offset and increment for the step-size check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_v   <= 1'b0;
            prev_off <= '0;
            prev_inc <= '0;
        end else begin
            prev_v   <= 1'b1;
            prev_off <= off_s;
            prev_inc <= $signed({4'b0000, inc_q});
        end
    end

    a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> offset == '0);
    a_r3_hold_between_steps: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(offset));
    a_r4_center_range: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !down_q) |-> (off_s <= pk_s && off_s >= -pk_s));
    a_r5_down_range: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && down_q) |-> (off_s <= 0 && off_s >= -(pk_s <<< 1)));
    a_r6_no_jump: assert property (@(posedge clk) disable iff (!rst_n)
        prev_v |-> (diff <= prev_inc && diff >= -prev_inc));
    a_r7_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> ($stable(down_q) && $stable(peak_q) && $stable(inc_q)));
    a_r8_mf_sum: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> mf_out == MF_W'($past(nom_mf) + off_ext));
endmodule

bind ssm_gen ssm_gen_chk #(.OFS_W(OFS_W), .MF_W(MF_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .idle   (idle),
    .tick   (tick),
    .down_q (down_q),
    .peak_q (peak_q),
    .inc_q  (inc_q),
    .offset (offset),
    .nom_mf (nom_mf),
    .mf_out (mf_out)
);

// File: tb/ssm_gen_test.sv
module ssm_gen_test;
    localparam int OFS_W = 12;
    localparam int MF_W  = 20;
    localparam int PER_W = 8;
    localparam int PK_W  = OFS_W - 2;
    localparam int MASK  = (1 << MF_W) - 1;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    mod_en = 1'b0;
    logic                    cfg_down = 1'b0;
    logic [PK_W-1:0]         cfg_peak = '0;
    logic [PK_W-1:0]         cfg_inc = '0;
    logic [PER_W-1:0]        cfg_period = '0;
    logic [MF_W-1:0]         nom_mf = '0;
    logic signed [OFS_W-1:0] offset;
    logic [MF_W-1:0]         mf_out;

    ssm_gen #(.OFS_W(OFS_W), .MF_W(MF_W), .PER_W(PER_W)) uut (
        .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .cfg_down(cfg_down),
        .cfg_peak(cfg_peak), .cfg_inc(cfg_inc), .cfg_period(cfg_period),
        .nom_mf(nom_mf), .offset(offset), .mf_out(mf_out)
    );

    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc_n = 0;
    bit done = 1'b0;
    int obs_max, obs_min;

    // Behavioural model built from the requirements.
    int m_st, m_acc, m_dir, m_cnt, m_down, m_peak, m_inc, m_mf;
    int last, u_down, u_peak, u_inc, hi, lo, nacc, ndir, nst, ci;
    bit t;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_acc = 0; m_dir = 1; m_cnt = 0;
            m_down = 0; m_peak = 0; m_inc = 1; m_mf = 0;
        end else begin
            last = (cfg_period == 0) ? 0 : int'(cfg_period) - 1;
            t = (m_st != 0) && (m_cnt >= last);
            ci = (cfg_inc == 0) ? 1 : int'(cfg_inc);
            u_down = (m_st == 0) ? int'(cfg_down) : m_down;
            u_peak = (m_st == 0) ? int'(cfg_peak) : m_peak;
            u_inc  = (m_st == 0) ? ci : m_inc;
            hi = u_down ? 0 : u_peak;
            lo = u_down ? -2 * u_peak : -u_peak;
            nacc = m_acc; ndir = m_dir; nst = m_st;
            if (m_st == 0) begin
                nacc = 0; ndir = !u_down;
                if (mod_en) nst = 1;
            end else begin
                if (m_st == 1 && mod_en) begin
                    if (t) begin
                        if (m_dir != 0) begin
                            if (m_acc + u_inc >= hi) begin nacc = hi; ndir = 0; end
                            else nacc = m_acc + u_inc;
                        end else begin
                            if (m_acc - u_inc <= lo) begin nacc = lo; ndir = 1; end
                            else nacc = m_acc - u_inc;
                        end
                    end
                end else if (t) begin
                    if (m_acc > 0)      nacc = (m_acc > u_inc) ? m_acc - u_inc : 0;
                    else if (m_acc < 0) nacc = (-m_acc > u_inc) ? m_acc + u_inc : 0;
                end
                if (m_st == 1 && !mod_en)       nst = 2;
                else if (m_st == 2 && m_acc == 0) nst = 0;
            end
            if (m_st == 0 || t) m_mf = (int'(nom_mf) + nacc) & MASK;
            if (m_st == 0) begin m_down = int'(cfg_down); m_peak = int'(cfg_peak); m_inc = ci; end
            m_cnt = (m_st == 0 || t) ? 0 : m_cnt + 1;
            m_acc = nacc; m_dir = ndir; m_st = nst;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc_n);
        end
    endtask

    // One cycle: wait for the falling edge, compare against the model.
    task automatic cyc();
        string tag;
        @(negedge clk);
        cyc_n++;
        if (m_st == 0) tag = "R2 idle offset";
        else if (int'(cfg_down) != m_down || int'(cfg_peak) != m_peak) tag = "R7 held config offset";
        else if (m_st == 2 || !mod_en) tag = "R6 return offset";
        else if (m_down != 0) tag = "R5 down offset";
        else tag = "R4 center offset";
        chk(tag, int'(offset), m_acc);
        chk("R8 mf_out", int'(mf_out), m_mf);
        if (int'(offset) > obs_max) obs_max = int'(offset);
        if (int'(offset) < obs_min) obs_min = int'(offset);
    endtask

    task automatic cycles(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic settle();
        mod_en = 1'b0;
        for (int i = 0; i < 3000 && m_st != 0; i++) cyc();
        cycles(3);
        chk("R6 back to zero", int'(offset), 0);
    endtask

    task automatic setup(bit dn, int pk, int inc, int per);
        cfg_down = dn; cfg_peak = PK_W'(pk); cfg_inc = PK_W'(inc); cfg_period = PER_W'(per);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R3: actual %0d cycles, expected completion", cyc_n);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int prev, lastc;
        bit seen;
        void'($urandom(32'd2024));
        nom_mf = 20'h4_0000;
        cycles(3);
        chk("R1 reset offset", int'(offset), 0);
        chk("R1 reset mf_out", int'(mf_out), 0);
        rst_n = 1'b1;
        cycles(3);
        chk("R2 idle mf_out nominal", int'(mf_out), 'h40000);

        // R4: center-spread reaches both bounds.
        setup(0, 20, 3, 2); mod_en = 1'b1;
        obs_max = 0; obs_min = 0;
        cycles(200);
        chk("R4 center crest", obs_max, 20);
        chk("R4 center trough", obs_min, -20);
        settle();

        // R5: down-spread reaches zero and minus twice the peak.
        setup(1, 15, 4, 1); mod_en = 1'b1;
        obs_max = -999; obs_min = 0;
        cycles(150);
        chk("R5 down crest", obs_max, 0);
        chk("R5 down trough", obs_min, -30);
        settle();

        // R9: zero period and increment behave as one.
        setup(0, 5, 0, 0); mod_en = 1'b1;
        cyc();
        prev = int'(offset); seen = 0;
        for (int i = 0; i < 20; i++) begin
            cyc();
            chk("R9 unit step", (int'(offset) - prev) * (int'(offset) - prev), 1);
            prev = int'(offset);
        end
        settle();

        // R3: steps spaced by the programmed period.
        setup(0, 50, 2, 5); mod_en = 1'b1;
        prev = 0; seen = 0; lastc = 0;
        for (int i = 0; i < 120; i++) begin
            cyc();
            if (int'(offset) != prev) begin
                if (!seen) chk("R3 first step", i + 1, 6);
                else       chk("R3 step interval", i - lastc, 5);
                lastc = i; seen = 1; prev = int'(offset);
            end
        end
        settle();

        // R7: config written mid-run is deferred until idle.
        setup(0, 10, 2, 1); mod_en = 1'b1;
        cycles(5);
        setup(1, 40, 5, 1);
        obs_max = 0; obs_min = 0;
        cycles(100);
        chk("R7 old crest kept", obs_max, 10);
        chk("R7 old trough kept", obs_min, -10);
        settle();
        mod_en = 1'b1; obs_min = 0;
        cycles(100);
        chk("R7 new trough after idle", obs_min, -80);
        settle();

        // Random episodes.
        for (int e = 0; e < 30; e++) begin
            setup(1'($urandom_range(0, 1)), $urandom_range(0, 60), $urandom_range(0, 7),
                  $urandom_range(0, 6));
            nom_mf = MF_W'($urandom());
            mod_en = 1'b1;
            for (int i = 0; i < int'($urandom_range(30, 300)); i++) begin
                if ($urandom_range(0, 40) == 0) begin
                    cfg_peak = PK_W'($urandom_range(0, 60));
                    cfg_down = 1'($urandom_range(0, 1));
                    cfg_inc  = PK_W'($urandom_range(0, 7));
                end
                if ($urandom_range(0, 60) == 0) cfg_period = PER_W'($urandom_range(0, 6));
                if ($urandom_range(0, 50) == 0) nom_mf = MF_W'($urandom());
                cyc();
            end
            settle();
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule